// File: doc/BRIEF.md
# Compare-Match Port Set/Clear/Toggle Unit

This block watches a free-running 16-bit timer value and compares it against three 16-bit compare values. Each compare channel has a fixed role. A hit on channel 0 drives selected bits of an 8-bit output port high. A hit on channel 1 drives selected bits low. A hit on channel 2 inverts selected bits. Three 8-bit enable masks decide which port bits follow each role. Every hit also raises a one-cycle interrupt pulse on that channel's own line.

The timer and any register access sit outside the block. The block sees only the timer value, the compare values and the masks. It produces the port, a toggle-status vector and the interrupt lines. A hit is edge-like: it fires only on the cycle in which the timer arrives at the compare value. A timer that stops on that value therefore does not fire it again. When roles collide on one bit in the same cycle, set and clear are resolved first, with clear winning, and the toggle is then applied to that result.

Top module: `cmp_port_unit`

## Requirements
- R1: Channel k (0, 1, 2) hits in a cycle when `timer_i` equals its compare input and `timer_i` differs from the value it had on the previous clock edge. Out of reset, that previous value is taken as 0. Bit k of `irq_o` is high for exactly the one cycle after the edge at which the hit is sampled, and low otherwise.
- R2: On a channel 0 hit, every port bit whose `set_en_i` bit is 1 reads 1 after the clock edge, unless R3 or R4 also act on that bit.
- R3: On a channel 1 hit, every port bit whose `clr_en_i` bit is 1 reads 0 after the clock edge. When channel 0 and channel 1 hit in the same cycle and both enable a bit, that bit reads 0, unless R4 acts on it.
- R4: On a channel 2 hit, every port bit whose `tgl_en_i` bit is 1 takes the inverse of the value produced by the set/clear step of that same cycle.
- R5: While `timer_i` holds the same value on consecutive edges, no channel hits, even if that value equals a compare input.
- R6: Bit i of `tgl_stat_o` takes the new value of port bit i whenever a channel 2 hit toggles that bit. It holds its value otherwise.
- R7: During and right after reset (`rst_ni` low), `port_o`, `tgl_stat_o` and `irq_o` are all 0.
- R8: Port bits not enabled by any channel that hits in a cycle keep their value. When no channel hits, the whole port holds.
- R9: Hits on several channels in the same cycle are each signalled on their own `irq_o` bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| timer_i | input | 16 | Running timer value |
| cmp0_i | input | 16 | Compare value for the set channel |
| cmp1_i | input | 16 | Compare value for the clear channel |
| cmp2_i | input | 16 | Compare value for the toggle channel |
| set_en_i | input | 8 | Port bits driven high on a channel 0 hit |
| clr_en_i | input | 8 | Port bits driven low on a channel 1 hit |
| tgl_en_i | input | 8 | Port bits inverted on a channel 2 hit |
| port_o | output | 8 | Output port |
| tgl_stat_o | output | 8 | Last value the toggle action produced, per bit |
| irq_o | output | 3 | Per-channel hit pulse, bit k for channel k |

## Verification
The assertions check the following on every cycle:
- A stalled timer never produces an interrupt.
- A cycle without interrupts leaves the port unchanged.
- A lone set hit or clear hit drives the enabled bits to the right level, and a clear hit does so whether or not a set hit also occurs.
- A lone toggle hit inverts exactly the enabled bits.
- The toggle status agrees with the port on every bit the toggle enables.

The following can only be shown by the bench scenarios:
- The exact ordering when all three roles strike one bit at once.
- The rule that the comparison right after reset is made against 0.
- Interrupts that coincide on several channels.
- The toggle status persisting across later set and clear activity.

// File: rtl/cmp_port_pkg.sv
package cmp_port_pkg;
  localparam int unsigned NUM_CH = 3;
  typedef enum logic [1:0] {
    CH_SET = 2'd0,
    CH_CLR = 2'd1,
    CH_TGL = 2'd2
  } ch_role_e;
endpackage

// File: rtl/cmp_match.sv
module cmp_match #(
  parameter int unsigned TW  = 16,
  parameter int unsigned NCH = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [TW-1:0]           timer_i,
  input  logic [NCH-1:0][TW-1:0]  cmp_i,
  output logic [NCH-1:0]          hit_o
);
  logic [TW-1:0] timer_q;
  logic          moved;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) timer_q <= '0;
    else         timer_q <= timer_i;
  end

  // only a timer arriving at the value counts
  assign moved = (timer_i != timer_q);

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign hit_o[k] = moved && (timer_i == cmp_i[k]);
  end
endmodule

// File: rtl/port_action.sv
module port_action #(
  parameter int unsigned PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_set_i,
  input  logic          hit_clr_i,
  input  logic          hit_tgl_i,
  input  logic [PW-1:0] set_en_i,
  input  logic [PW-1:0] clr_en_i,
  input  logic [PW-1:0] tgl_en_i,
  output logic [PW-1:0] port_o,
  output logic [PW-1:0] tgl_stat_o
);
  logic [PW-1:0] port_q, stat_q;
  logic [PW-1:0] set_m, clr_m, tgl_m, resolved, port_d;

  assign set_m    = hit_set_i ? set_en_i : '0;
  assign clr_m    = hit_clr_i ? clr_en_i : '0;
  assign tgl_m    = hit_tgl_i ? tgl_en_i : '0;
  // clear dominates set; toggle acts on the resolved value
  assign resolved = (port_q | set_m) & ~clr_m;
  assign port_d   = resolved ^ tgl_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_q <= '0;
      stat_q <= '0;
    end else begin
      port_q <= port_d;
      stat_q <= (stat_q & ~tgl_m) | (port_d & tgl_m);
    end
  end

  assign port_o     = port_q;
  assign tgl_stat_o = stat_q;
endmodule

// File: rtl/cmp_port_unit.sv
module cmp_port_unit
  import cmp_port_pkg::*;
#(
  parameter int unsigned TW = 16,
  parameter int unsigned PW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TW-1:0]     timer_i,
  input  logic [TW-1:0]     cmp0_i,
  input  logic [TW-1:0]     cmp1_i,
  input  logic [TW-1:0]     cmp2_i,
  input  logic [PW-1:0]     set_en_i,
  input  logic [PW-1:0]     clr_en_i,
  input  logic [PW-1:0]     tgl_en_i,
  output logic [PW-1:0]     port_o,
  output logic [PW-1:0]     tgl_stat_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0][TW-1:0] cmp_vec;
  logic [NUM_CH-1:0]         hit;
  logic [NUM_CH-1:0]         irq_q;

  assign cmp_vec[CH_SET] = cmp0_i;
  assign cmp_vec[CH_CLR] = cmp1_i;
  assign cmp_vec[CH_TGL] = cmp2_i;

  cmp_match #(.TW(TW), .NCH(NUM_CH)) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .timer_i (timer_i),
    .cmp_i   (cmp_vec),
    .hit_o   (hit)
  );

  port_action #(.PW(PW)) u_act (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_set_i  (hit[CH_SET]),
    .hit_clr_i  (hit[CH_CLR]),
    .hit_tgl_i  (hit[CH_TGL]),
    .set_en_i   (set_en_i),
    .clr_en_i   (clr_en_i),
    .tgl_en_i   (tgl_en_i),
    .port_o     (port_o),
    .tgl_stat_o (tgl_stat_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= hit;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/cmp_port_unit_chk.sv
module cmp_port_unit_chk #(
  parameter int unsigned TW = 16,
  parameter int unsigned PW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [TW-1:0] timer_i,
  input logic [TW-1:0] cmp0_i,
  input logic [TW-1:0] cmp1_i,
  input logic [TW-1:0] cmp2_i,
  input logic [PW-1:0] set_en_i,
  input logic [PW-1:0] clr_en_i,
  input logic [PW-1:0] tgl_en_i,
  input logic [PW-1:0] port_o,
  input logic [PW-1:0] tgl_stat_o,
  input logic [2:0]    irq_o
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R5
  stall_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && timer_i == $past(timer_i)) |=> (irq_o == 3'b000));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && irq_o == 3'b000) |-> (port_o == $past(port_o)));

  // R2
  set_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && irq_o == 3'b001) |-> ((port_o & $past(set_en_i)) == $past(set_en_i)));

  // R3
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && irq_o[1] && !irq_o[2]) |-> ((port_o & $past(clr_en_i)) == '0));

  // R4
  tgl_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && irq_o == 3'b100) |-> (port_o == ($past(port_o) ^ $past(tgl_en_i))));

  // R6
  tgl_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && irq_o[2]) |-> ((tgl_stat_o & $past(tgl_en_i)) == (port_o & $past(tgl_en_i))));

  // R7
  always_comb begin
    if (!rst_ni) begin
      reset_state_chk: assert (port_o == '0 && tgl_stat_o == '0 && irq_o == '0);
    end
  end
endmodule

bind cmp_port_unit cmp_port_unit_chk #(.TW(TW), .PW(PW)) u_chk (.*);

// File: tb/cmp_port_unit_tb.sv
module cmp_port_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] timer, c0, c1, c2;
  logic [7:0]  se, ce, te;
  logic [7:0]  port, tstat;
  logic [2:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] ref_prev;
  logic [7:0]  ref_port, ref_tgl;
  logic [2:0]  ref_irq;
  string       last_tag;

  always #10 clk = ~clk;

  cmp_port_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .timer_i(timer),
    .cmp0_i(c0), .cmp1_i(c1), .cmp2_i(c2),
    .set_en_i(se), .clr_en_i(ce), .tgl_en_i(te),
    .port_o(port), .tgl_stat_o(tstat), .irq_o(irq)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] next_port(input logic [7:0] p, input logic [7:0] s,
                                           input logic [7:0] c, input logic [7:0] t);
    return ((p | s) & ~c) ^ t;
  endfunction

  task automatic check_now();
    chk(last_tag, "port", {24'd0, port}, {24'd0, ref_port});
    chk(last_tag, "tgl_stat", {24'd0, tstat}, {24'd0, ref_tgl});
    chk(last_tag, "irq", {29'd0, irq}, {29'd0, ref_irq});
  endtask

  task automatic step(input logic [15:0] t, input logic [15:0] a0, input logic [15:0] a1,
                      input logic [15:0] a2, input logic [7:0] ms, input logic [7:0] mc,
                      input logic [7:0] mt, input string tag);
    logic m0, m1, m2;
    logic [7:0] s, c, tt, np;
    @(negedge clk);
    check_now();
    timer = t; c0 = a0; c1 = a1; c2 = a2; se = ms; ce = mc; te = mt;
    m0 = (t == a0) && (t != ref_prev);
    m1 = (t == a1) && (t != ref_prev);
    m2 = (t == a2) && (t != ref_prev);
    s  = m0 ? ms : 8'h00;
    c  = m1 ? mc : 8'h00;
    tt = m2 ? mt : 8'h00;
    np = next_port(ref_port, s, c, tt);
    ref_tgl  = (ref_tgl & ~tt) | (np & tt);
    ref_port = np;
    ref_irq  = {m2, m1, m0};
    ref_prev = t;
    last_tag = tag;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] base;
    int unsigned dummy;
    dummy = $urandom(32'd2024);
    timer = 16'd0; c0 = 16'hFFFF; c1 = 16'hFFFF; c2 = 16'hFFFF;
    se = 8'h00; ce = 8'h00; te = 8'h00;
    ref_prev = 16'd0; ref_port = 8'h00; ref_tgl = 8'h00; ref_irq = 3'b000;
    last_tag = "R7 reset";
    repeat (3) @(negedge clk);
    check_now();  // R7 during reset
    rst_ni = 1'b1;

    // R1 R2: first hit on the set channel
    step(16'd5, 16'd5, 16'hFFFF, 16'hFFFF, 8'h0F, 8'hFF, 8'hFF, "R1 R2 set");
    // R5 R8: timer stalls on the compare value
    step(16'd5, 16'd5, 16'd5, 16'd5, 8'hF0, 8'hFF, 8'hFF, "R5 stall");
    step(16'd5, 16'd5, 16'd5, 16'd5, 8'hF0, 8'hFF, 8'hFF, "R8 hold");
    // R3: clear
    step(16'd6, 16'hFFFF, 16'd6, 16'hFFFF, 8'h00, 8'h03, 8'h00, "R3 clear");
    // R3: clear wins over set on shared bits
    step(16'd7, 16'd7, 16'd7, 16'hFFFF, 8'hF1, 8'hF0, 8'h00, "R3 conflict");
    // R4 R6: toggle all bits
    step(16'd8, 16'hFFFF, 16'hFFFF, 16'd8, 8'h00, 8'h00, 8'hFF, "R4 toggle");
    // R4 R9: all three hit bit 7
    step(16'd9, 16'd9, 16'd9, 16'd9, 8'h80, 8'h80, 8'h80, "R4 R9 all three");
    // R6: toggle twice on one bit, then set and clear activity elsewhere
    step(16'd10, 16'hFFFF, 16'hFFFF, 16'd10, 8'h00, 8'h00, 8'h02, "R6 toggle a");
    step(16'd11, 16'hFFFF, 16'hFFFF, 16'd11, 8'h00, 8'h00, 8'h02, "R6 toggle b");
    step(16'd12, 16'd12, 16'hFFFF, 16'hFFFF, 8'h02, 8'h00, 8'h00, "R6 set after toggle");
    step(16'd13, 16'hFFFF, 16'd13, 16'hFFFF, 8'h00, 8'h02, 8'h00, "R6 clear after toggle");
    // R1: a compare on the old value does not fire
    step(16'd14, 16'd13, 16'd13, 16'd13, 8'hFF, 8'hFF, 8'hFF, "R1 no hit");

    // R9: random, timer mostly counting, compares in a nearby window
    base = 16'd100;
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom_range(0, 9);
      if (r < 6)       base = base + 16'd1;
      else if (r == 9) base = 16'($urandom);
      step(base,
           base + 16'($urandom_range(0, 3)),
           base + 16'($urandom_range(0, 3)),
           base + 16'($urandom_range(0, 3)),
           8'($urandom), 8'($urandom), 8'($urandom), "R9 random");
    end
    @(negedge clk);
    check_now();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule